// File: doc/BRIEF.md
# Character-Cell Text Panel Renderer

This block draws a text panel, pixel by pixel, from a memory of character codes. For each pixel position inside the panel it forms the address of the character cell that covers the position and presents it on a read-only memory port. One clock later it takes the returned 8-bit code and looks up that code's glyph at the in-cell row and column. It then registers a 3-bit RGB pixel.

The panel is a grid of 32 columns by 16 rows of 8x8-pixel cells. Letters, digits and punctuation are stored as keyboard set-2 scan-code values rather than ASCII, so a key handler can write its received codes directly. A few low codes draw the panel's frame. Another agent fills the character memory through its own write port, and this block only reads it. The block runs on the pixel clock, and a text-area enable from the display timing blanks the output outside the panel.

Top module: `tbox_render`

## Requirements
- R1: The memory address is {cell row, cell column}, with the column in the low 5 bits. The cell column is pix_x_i[7:3] and the cell row is pix_y_i[6:3]. The address follows the position inputs with no register in between.
- R2: The pixel for the position and enable presented before a clock edge appears on pix_o after the next edge, which is two edges later in all. The in-cell offsets pix_x_i[2:0] (column) and pix_y_i[2:0] (row) stay aligned with the code returned by the memory.
- R3: While the enable was low for a pixel, that pixel is 3'b000.
- R4: While rst_ni is low, pix_o is 3'b000, whatever the inputs are.
- R5: Code 8'h00 is blank: every pixel of the cell is 3'b000.
- R6: A lit glyph pixel outputs white (3'b111, with red in bit 2), and an unlit one outputs black (3'b000).
- R7: Code 8'h07 (side edge) lights columns 3 and 4 in every row.
- R8: Codes 8'h04 (top edge) and 8'h05 (bottom edge) light rows 3 and 4 in every column.
- R9: Code 8'h01 (top corner) lights rows 3 and 4 in columns 3 to 7, and columns 3 and 4 in rows 3 to 7.
- R10: Code 8'h03 (bottom corner) lights rows 3 and 4 in columns 3 to 7, and columns 3 and 4 in rows 0 to 4.
- R11: Code 8'h4E ('-') lights only row 3, columns 1 to 5.
- R12: The scan-code glyphs 8'h2B F, 8'h1B S, 8'h2C T, 8'h44 O, 8'h4D P, 8'h1C A, 8'h24 E and 8'h16 '1' each light at least one pixel. Each leaves row 7 and column 7 dark as spacing.
- R13: Any code with no glyph, including every code of 8'h80 or above, renders blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| text_en_i | input | 1 | Position lies in the text panel |
| pix_x_i | input | 8 | Pixel column relative to panel origin |
| pix_y_i | input | 7 | Pixel row relative to panel origin |
| cmem_addr_o | output | 9 | Character memory read address |
| cmem_data_i | input | 8 | Code read from memory, one cycle after the address |
| pix_o | output | 3 | RGB pixel {red, green, blue} |

## Verification
The bench builds the block with its default 32x16 grid, so the 8-bit x and 7-bit y inputs span exactly the 512 cell addresses. The random stream therefore reaches every cell, including the last column and row. With the default white-on-black colours, the exact frame, dash and blank patterns can be predicted bit for bit. A back-to-back random position stream changes the cell and offset every cycle, which exposes any skew between the code and the offsets. Full 64-pixel sweeps check each frame glyph, the dash glyph, the letters and the undefined codes.

// File: rtl/tbox_pkg.sv
package tbox_pkg;
  localparam int GLYPH_LOG = 3;
  localparam int GLYPH_N   = 1 << GLYPH_LOG;
  localparam int CODE_W    = 8;
  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [GLYPH_LOG-1:0] off_t;
endpackage

// File: rtl/tbox_addr.sv
module tbox_addr
  import tbox_pkg::*;
#(
  parameter int COLS = 32,
  parameter int ROWS = 16,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int X_W    = COL_W + GLYPH_LOG,
  localparam int Y_W    = ROW_W + GLYPH_LOG,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [X_W-1:0]    pix_x_i,
  input  logic [Y_W-1:0]    pix_y_i,
  output logic [ADDR_W-1:0] addr_o,
  output off_t              off_x_o,
  output off_t              off_y_o,
  output logic              en_o
);
  assign addr_o = {pix_y_i[Y_W-1:GLYPH_LOG], pix_x_i[X_W-1:GLYPH_LOG]};

  // offsets wait one cycle for the memory read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_x_o <= '0;
      off_y_o <= '0;
      en_o    <= 1'b0;
    end else begin
      off_x_o <= pix_x_i[GLYPH_LOG-1:0];
      off_y_o <= pix_y_i[GLYPH_LOG-1:0];
      en_o    <= en_i;
    end
  end

  // R1
  addr_cell_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(pix_x_i[X_W-1:GLYPH_LOG]) && $stable(pix_y_i[Y_W-1:GLYPH_LOG])) |-> $stable(addr_o));

  // R2
  off_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (off_x_o == $past(pix_x_i[GLYPH_LOG-1:0]) && off_y_o == $past(pix_y_i[GLYPH_LOG-1:0])));
endmodule

// File: rtl/tbox_glyph_rom.sv
module tbox_glyph_rom
  import tbox_pkg::*;
(
  input  code_t code_i,
  input  off_t  row_i,
  input  off_t  col_i,
  output logic  bit_o
);
  logic [7*GLYPH_N-1:0] shape;
  logic [GLYPH_N-1:0]   line;
  logic                 frame_bit;
  logic                 mid_r, mid_c, right_c, low_r, high_r;

  // seven stored rows per scan-code glyph, row 7 is spacing; bit 7 = column 0
  always_comb begin
    unique case (code_i)
      8'h2B:   shape = 56'h7C_40_40_78_40_40_40;
      8'h1B:   shape = 56'h3C_40_40_38_04_04_78;
      8'h2C:   shape = 56'h7C_10_10_10_10_10_10;
      8'h44:   shape = 56'h38_44_44_44_44_44_38;
      8'h4D:   shape = 56'h78_44_44_78_40_40_40;
      8'h1C:   shape = 56'h38_44_44_7C_44_44_44;
      8'h24:   shape = 56'h7C_40_40_78_40_40_7C;
      8'h16:   shape = 56'h10_30_10_10_10_10_38;
      8'h4E:   shape = 56'h00_00_00_7C_00_00_00;
      default: shape = '0;
    endcase
  end

  always_comb begin
    line = '0;
    for (int r = 0; r < 7; r++)
      if (int'(row_i) == r) line = shape[(6-r)*GLYPH_N +: GLYPH_N];
  end

  // frame glyphs from line primitives
  always_comb begin
    mid_r   = (row_i == 3'd3) || (row_i == 3'd4);
    mid_c   = (col_i == 3'd3) || (col_i == 3'd4);
    right_c = (col_i >= 3'd3);
    low_r   = (row_i >= 3'd3);
    high_r  = (row_i <= 3'd4);
    unique case (code_i)
      8'h07:        frame_bit = mid_c;
      8'h04, 8'h05: frame_bit = mid_r;
      8'h01:        frame_bit = (mid_r && right_c) || (mid_c && low_r);
      8'h03:        frame_bit = (mid_r && right_c) || (mid_c && high_r);
      default:      frame_bit = 1'b0;
    endcase
  end

  assign bit_o = line[GLYPH_N-1-int'(col_i)] | frame_bit;
endmodule

// File: rtl/tbox_pix.sv
module tbox_pix #(
  parameter logic [2:0] FG_RGB = 3'b111,
  parameter logic [2:0] BG_RGB = 3'b000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [2:0] pix_o
);
  logic [2:0] pix_d;

  for (genvar k = 0; k < 3; k++) begin : g_chan
    assign pix_d[k] = en_i & (bit_i ? FG_RGB[k] : BG_RGB[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= pix_d;
  end

  // R3
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pix_o == 3'b000));

  // R6
  colour_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == FG_RGB) || (pix_o == BG_RGB) || (pix_o == 3'b000));
endmodule

// File: rtl/tbox_render.sv
module tbox_render
  import tbox_pkg::*;
#(
  parameter int COLS = 32,
  parameter int ROWS = 16,
  parameter logic [2:0] FG_RGB = 3'b111,
  parameter logic [2:0] BG_RGB = 3'b000,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int X_W    = COL_W + GLYPH_LOG,
  localparam int Y_W    = ROW_W + GLYPH_LOG,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              text_en_i,
  input  logic [X_W-1:0]    pix_x_i,
  input  logic [Y_W-1:0]    pix_y_i,
  output logic [ADDR_W-1:0] cmem_addr_o,
  input  logic [CODE_W-1:0] cmem_data_i,
  output logic [2:0]        pix_o
);
  off_t off_x, off_y;
  logic en_s, glyph_bit;

  tbox_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (text_en_i),
    .pix_x_i (pix_x_i),
    .pix_y_i (pix_y_i),
    .addr_o  (cmem_addr_o),
    .off_x_o (off_x),
    .off_y_o (off_y),
    .en_o    (en_s)
  );

  tbox_glyph_rom u_rom (
    .code_i (cmem_data_i),
    .row_i  (off_y),
    .col_i  (off_x),
    .bit_o  (glyph_bit)
  );

  tbox_pix #(.FG_RGB(FG_RGB), .BG_RGB(BG_RGB)) u_pix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_s),
    .bit_i  (glyph_bit),
    .pix_o  (pix_o)
  );

  // R5
  blank_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmem_data_i == 8'h00) |-> !glyph_bit);

  // R13
  high_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmem_data_i[CODE_W-1] |-> !glyph_bit);
endmodule

// File: tb/sim_tbox_render.sv
module sim_tbox_render;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] px = '0;
  logic [6:0] py = '0;
  logic [8:0] addr;
  logic [7:0] rdata = '0;
  logic [2:0] pix;
  logic [7:0] mem [512];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tbox_render u0 (
    .clk_i(clk), .rst_ni(rst_n), .text_en_i(en), .pix_x_i(px), .pix_y_i(py),
    .cmem_addr_o(addr), .cmem_data_i(rdata), .pix_o(pix)
  );

  always @(posedge clk) rdata <= mem[addr];

  function automatic bit exp_bit(input logic [7:0] c, input int r, input int k);
    bit mr = (r == 3 || r == 4), mc = (k == 3 || k == 4);
    case (c)
      8'h07: return mc;
      8'h04, 8'h05: return mr;
      8'h01: return (mr && k >= 3) || (mc && r >= 3);
      8'h03: return (mr && k >= 3) || (mc && r <= 4);
      8'h4E: return (r == 3 && k >= 1 && k <= 5);
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] exp_pix(input logic [7:0] c, input int r, input int k, input bit e);
    return (e && exp_bit(c, r, k)) ? 3'b111 : 3'b000;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [7:0] x, input logic [6:0] y, input bit e, output logic [2:0] rgb);
    @(negedge clk);
    px = x; py = y; en = e;
    #1 chk("R1 addr", addr, {y[6:3], x[7:3]});
    @(negedge clk);
    @(negedge clk);
    rgb = pix;
  endtask

  task automatic sweep(input logic [7:0] c, input string req);
    logic [2:0] rgb;
    int cx = $urandom_range(31), cy = $urandom_range(15);
    mem[{cy[3:0], cx[4:0]}] = c;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 8; k++) begin
        probe({cx[4:0], k[2:0]}, {cy[3:0], r[2:0]}, 1'b1, rgb);
        chk(req, {6'd0, rgb}, {6'd0, exp_pix(c, r, k, 1'b1)});
      end
    mem[{cy[3:0], cx[4:0]}] = 8'h00;
  endtask

  task automatic letter(input logic [7:0] c);
    logic [2:0] rgb;
    int lit = 0, edge_lit = 0;
    mem[9'h0A5] = c;
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 8; k++) begin
        probe({5'd5, k[2:0]}, {4'd5, r[2:0]}, 1'b1, rgb);
        if (rgb == 3'b111) begin
          lit++;
          if (r == 7 || k == 7) edge_lit++;
        end else chk("R6 colour", {6'd0, rgb}, 9'd0);
      end
    chk("R12 lit", {8'd0, lit > 0}, 9'd1);
    chk("R12 spacing", edge_lit[8:0], 9'd0);
    mem[9'h0A5] = 8'h00;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] rgb;
    logic [2:0] q_e1, q_e2;
    bit v1, v2;
    int s;
    logic [7:0] pool [8] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h07, 8'h4E, 8'h99};
    s = $urandom(32'd20250);
    foreach (mem[i]) mem[i] = 8'h00;
    // R4: reset holds black even with a lit pixel selected
    mem[0] = 8'h07;
    px = 8'd3; py = 7'd0; en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 reset", {6'd0, pix}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 white after reset", {6'd0, pix}, 9'h7);
    // R3: enable low on a lit pixel
    probe(8'd3, 7'd0, 1'b0, rgb);
    chk("R3 en low", {6'd0, rgb}, 9'd0);
    mem[0] = 8'h00;

    sweep(8'h00, "R5 blank");
    sweep(8'h07, "R7 side");
    sweep(8'h04, "R8 top");
    sweep(8'h05, "R8 bottom");
    sweep(8'h01, "R9 corner");
    sweep(8'h03, "R10 corner");
    sweep(8'h4E, "R11 dash");
    sweep(8'h99, "R13 undef");
    sweep(8'h02, "R13 undef");
    sweep(8'hFF, "R13 undef");
    foreach (pool[i]) if (i == 0) begin
      letter(8'h2B); letter(8'h1B); letter(8'h2C); letter(8'h44);
      letter(8'h4D); letter(8'h1C); letter(8'h24); letter(8'h16);
    end

    // R2: back-to-back random stream, checked two cycles after drive
    foreach (mem[i]) mem[i] = pool[$urandom_range(7)];
    v1 = 0; v2 = 0; q_e1 = '0; q_e2 = '0;
    for (int t = 0; t < 3000; t++) begin
      logic [7:0] x;
      logic [6:0] y;
      bit e;
      @(negedge clk);
      if (v2) chk("R2 stream", {6'd0, pix}, {6'd0, q_e2});
      v2 = v1; q_e2 = q_e1;
      x = 8'($urandom); y = 7'($urandom); e = ($urandom_range(9) != 0);
      px = x; py = y; en = e;
      q_e1 = exp_pix(mem[{y[6:3], x[7:3]}], int'(y[2:0]), int'(x[2:0]), e);
      v1 = 1;
      #1 chk("R1 addr", addr, {y[6:3], x[7:3]});
    end
    @(negedge clk);
    chk("R2 stream", {6'd0, pix}, {6'd0, q_e2});
    @(negedge clk);
    chk("R2 stream", {6'd0, pix}, {6'd0, q_e1});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule